// File: doc/BRIEF.md
# Composite Sync Classifier with Burst Gate

This block watches an active-low composite sync input that runs in step with the four-times-subcarrier clock, which also clocks every register here. It counts how many clock cycles each sync pulse stays low. When the pulse ends, the count places the pulse in one of three classes. A width inside the acceptance window for the selected television standard marks a valid horizontal sync. A narrower pulse is an equalizing or serration pulse. A wider pulse is a broad vertical pulse.

A valid horizontal sync produces a one-cycle line-start strobe. It also starts a burst gate sequence: a fixed hold, and then a gate that stays open for eight subcarrier periods. No other class of pulse can open the gate. A broad pulse produces a one-cycle flag. The first broad pulse that follows a valid horizontal sync marks a vertical interval. Every other vertical interval raises a one-cycle frame-start strobe.

The block has three submodules. A pulse meter state machine measures and classifies each pulse. A burst sequencer state machine times the gate. A field detector arms itself on line syncs and tracks the parity of vertical intervals.

Top module: `csync_classifier`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, line_start, burst_gate, broad_pulse and frame_start are all 0.
- R2: With pal_mode = 0, a low pulse of 36 to 76 clock cycles, both limits included, gives line_start = 1 for exactly one cycle. That cycle is the one after the first clock edge that samples sync_n high again.
- R3: With pal_mode = 1, the window is 40 to 97 cycles, both limits included, with the same strobe timing as R2. pal_mode is sampled at the end of the pulse.
- R4: A pulse shorter than the lower limit of the selected window gives no line_start, no broad_pulse and no burst_gate.
- R5: A pulse longer than the upper limit gives broad_pulse = 1 for one cycle, aligned with where line_start would be. It gives no line_start and no burst_gate.
- R6: If line_start is high in cycle t, burst_gate is high in cycles t+8 through t+39 and low in cycle t+7 and in cycle t+40. A line_start that arrives while a burst sequence is already running is ignored.
- R7: A broad pulse that follows at least one valid horizontal sync starts a new vertical interval; later broad pulses in the same interval are ignored. frame_start equals broad_pulse on the 1st, 3rd, 5th and later odd-numbered intervals counted from reset, and stays 0 on the even-numbered ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Four-times-subcarrier clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_n | input | 1 | Composite sync, low during a pulse, synchronous to clk |
| pal_mode | input | 1 | 1 selects the 625-line window, 0 selects the 525-line window |
| line_start | output | 1 | One-cycle strobe after a valid horizontal sync |
| burst_gate | output | 1 | High while the colour burst may be inserted |
| broad_pulse | output | 1 | One-cycle flag after a pulse wider than the window |
| frame_start | output | 1 | One-cycle strobe on alternate vertical intervals |

## Verification
Directed pulses sit on either side of each window limit in both standards: 35/36/76/77 and 39/40/97/98 cycles. They show that both limits are inclusive and that each standard uses its own window. Widths of 38 and 90 fall in one window only, so a mix-up between the two windows shows up. A directed sequence mixes line syncs with runs of broad pulses. It checks arming, that repeated broad pulses are ignored, and that frame strobes fall only on alternate intervals. Widths drawn at random with a fixed seed, in a random standard, cover all three classes. For every pulse the bench compares all four outputs cycle by cycle against its own model, so that burst gate timing and missing or stray strobes are caught.

// File: rtl/csync_pkg.sv
package csync_pkg;

    typedef enum logic {
        M_HIGH,
        M_LOW
    } meter_state_t;

    typedef enum logic [1:0] {
        B_IDLE,
        B_HOLD,
        B_OPEN
    } burst_state_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/csync_pulse_meter.sv
module csync_pulse_meter
    import csync_pkg::*;
#(
    parameter int unsigned NTSC_MIN = 36,
    parameter int unsigned NTSC_MAX = 76,
    parameter int unsigned PAL_MIN  = 40,
    parameter int unsigned PAL_MAX  = 97,
    parameter int unsigned CNT_W    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_n,
    input  logic pal_mode,
    output logic valid_hs,
    output logic broad
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    meter_state_t state_q, state_d;
    logic [CNT_W-1:0] width_q;
    logic [CNT_W-1:0] lo_lim, hi_lim;
    logic trail;

    always_comb begin
        lo_lim = pal_mode ? CNT_W'(PAL_MIN) : CNT_W'(NTSC_MIN);
        hi_lim = pal_mode ? CNT_W'(PAL_MAX) : CNT_W'(NTSC_MAX);
    end

    always_comb begin
        state_d = state_q;
        trail   = 1'b0;
        unique case (state_q)
            M_HIGH: if (!sync_n) state_d = M_LOW;
            M_LOW: begin
                if (sync_n) begin
                    state_d = M_HIGH;
                    trail   = 1'b1;
                end
            end
            default: state_d = M_HIGH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= M_HIGH;
            width_q <= '0;
        end else begin
            state_q <= state_d;
            if (!sync_n) begin
                if (state_q == M_HIGH)
                    width_q <= CNT_W'(1);
                else if (width_q != CNT_TOP)
                    width_q <= width_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_hs <= 1'b0;
            broad    <= 1'b0;
        end else begin
            valid_hs <= trail && (width_q >= lo_lim) && (width_q <= hi_lim);
            broad    <= trail && (width_q > hi_lim);
        end
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_hs |=> !valid_hs); // R2
    AST_CLASS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_hs && broad)); // R5

endmodule

// File: rtl/csync_burst_seq.sv
module csync_burst_seq
    import csync_pkg::*;
#(
    parameter int unsigned DELAY = 8,
    parameter int unsigned LEN   = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic gate
);

    localparam int unsigned DW = $clog2(max2(DELAY, LEN) + 1);
    localparam int unsigned SW = $clog2(DELAY + LEN + 2) + 1;
    localparam logic [DW-1:0] HOLD_END = DW'(DELAY - 2);
    localparam logic [DW-1:0] OPEN_END = DW'(LEN - 1);

    burst_state_t state_q, state_d;
    logic [DW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            B_IDLE: if (trig) state_d = B_HOLD;
            B_HOLD: if (cnt_q == HOLD_END) state_d = B_OPEN;
            B_OPEN: if (cnt_q == OPEN_END) state_d = B_IDLE;
            default: state_d = B_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= B_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? '0 : cnt_q + DW'(1);
        end
    end

    always_comb gate = (state_q == B_OPEN);

    logic [SW-1:0] since_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_q <= '1;
        else if (trig && state_q == B_IDLE)
            since_q <= SW'(1);
        else if (since_q != '1)
            since_q <= since_q + SW'(1);
    end

    AST_GATE_OPEN_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> (since_q == SW'(DELAY))); // R6
    AST_GATE_CLOSE_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate) |-> (since_q == SW'(DELAY + LEN))); // R6

endmodule

// File: rtl/csync_field_det.sv
module csync_field_det (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_hs,
    input  logic broad,
    output logic frame_start
);

    logic armed_q;
    logic odd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            odd_q   <= 1'b0;
        end else if (valid_hs) begin
            armed_q <= 1'b1;
        end else if (broad && armed_q) begin
            armed_q <= 1'b0;
            odd_q   <= ~odd_q;
        end
    end

    always_comb frame_start = broad && armed_q && !odd_q;

    AST_FRAME_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start); // R7

endmodule

// File: rtl/csync_classifier.sv
module csync_classifier
    import csync_pkg::*;
#(
    parameter int unsigned NTSC_MIN    = 36,
    parameter int unsigned NTSC_MAX    = 76,
    parameter int unsigned PAL_MIN     = 40,
    parameter int unsigned PAL_MAX     = 97,
    parameter int unsigned BURST_DELAY = 8,
    parameter int unsigned BURST_LEN   = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_n,
    input  logic pal_mode,
    output logic line_start,
    output logic burst_gate,
    output logic broad_pulse,
    output logic frame_start
);

    localparam int unsigned TOP_LIM = max2(NTSC_MAX, PAL_MAX);
    localparam int unsigned CNT_W   = $clog2(TOP_LIM + 1) + 1;

    logic valid_hs;
    logic broad;

    csync_pulse_meter #(
        .NTSC_MIN(NTSC_MIN),
        .NTSC_MAX(NTSC_MAX),
        .PAL_MIN (PAL_MIN),
        .PAL_MAX (PAL_MAX),
        .CNT_W   (CNT_W)
    ) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_n  (sync_n),
        .pal_mode(pal_mode),
        .valid_hs(valid_hs),
        .broad   (broad)
    );

    csync_burst_seq #(
        .DELAY(BURST_DELAY),
        .LEN  (BURST_LEN)
    ) u_burst (
        .clk  (clk),
        .rst_n(rst_n),
        .trig (valid_hs),
        .gate (burst_gate)
    );

    csync_field_det u_field (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_hs   (valid_hs),
        .broad      (broad),
        .frame_start(frame_start)
    );

    always_comb begin
        line_start  = valid_hs;
        broad_pulse = broad;
    end

    AST_STROBE_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start || broad_pulse) |-> $past(!sync_n, 2)); // R5

endmodule

// File: tb/sim_csync_classifier.sv
module sim_csync_classifier;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_n = 1'b1;
    logic pal_mode = 1'b0;
    logic line_start, burst_gate, broad_pulse, frame_start;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit m_armed = 1'b0;
    bit m_odd = 1'b0;

    always #4 clk = ~clk;

    csync_classifier u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_n     (sync_n),
        .pal_mode   (pal_mode),
        .line_start (line_start),
        .burst_gate (burst_gate),
        .broad_pulse(broad_pulse),
        .frame_start(frame_start)
    );

    // 0 short, 1 valid line sync, 2 broad
    function automatic int classify(input int w, input bit pal);
        int lo;
        int hi;
        lo = pal ? 40 : 36;
        hi = pal ? 97 : 76;
        if (w < lo) return 0;
        if (w > hi) return 2;
        return 1;
    endfunction

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got ls/bg/bp/fs=%b expected %b at t=%0t", req, got, exp, $time);
        end
    endtask

    task automatic run_pulse(input int w, input bit pal);
        int cls;
        bit fs;
        string tag;
        logic [3:0] exp;
        pal_mode = pal;
        cls = classify(w, pal);
        fs = 1'b0;
        if (cls == 1) m_armed = 1'b1;
        if (cls == 2 && m_armed) begin
            fs = ~m_odd;
            m_odd = ~m_odd;
            m_armed = 1'b0;
        end
        if (cls == 1) tag = pal ? "R3" : "R2";
        else if (cls == 2) tag = fs ? "R7" : "R5";
        else tag = "R4";
        @(negedge clk);
        sync_n = 1'b0;
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            check(tag, {line_start, burst_gate, broad_pulse, frame_start}, 4'b0000);
        end
        sync_n = 1'b1;
        for (int k = 1; k <= 48; k++) begin
            @(negedge clk);
            exp = 4'b0000;
            if (k == 1 && cls == 1) exp[3] = 1'b1;
            if (k >= 9 && k <= 40 && cls == 1) exp[2] = 1'b1;
            if (k == 1 && cls == 2) exp[1] = 1'b1;
            if (k == 1) exp[0] = fs;
            check((k > 1 && cls == 1) ? "R6" : tag,
                  {line_start, burst_gate, broad_pulse, frame_start}, exp);
        end
    endtask

    initial begin
        int w;
        bit p;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R1", {line_start, burst_gate, broad_pulse, frame_start}, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {line_start, burst_gate, broad_pulse, frame_start}, 4'b0000);

        // window edges, 525-line standard (R2, R4, R5)
        run_pulse(35, 1'b0);
        run_pulse(36, 1'b0);
        run_pulse(76, 1'b0);
        run_pulse(77, 1'b0);
        // window edges, 625-line standard (R3)
        run_pulse(39, 1'b1);
        run_pulse(40, 1'b1);
        run_pulse(97, 1'b1);
        run_pulse(98, 1'b1);
        // widths inside one window only
        run_pulse(38, 1'b0);
        run_pulse(38, 1'b1);
        run_pulse(90, 1'b1);
        run_pulse(90, 1'b0);
        run_pulse(1, 1'b0);
        run_pulse(200, 1'b0);
        // vertical interval sequence (R7)
        run_pulse(60, 1'b0);
        run_pulse(150, 1'b0);
        run_pulse(150, 1'b0);
        run_pulse(20, 1'b0);
        run_pulse(60, 1'b0);
        run_pulse(150, 1'b0);
        run_pulse(60, 1'b0);
        run_pulse(120, 1'b1);
        run_pulse(130, 1'b1);

        for (int n = 0; n < 80; n++) begin
            w = 1 + int'($urandom_range(0, 179));
            p = 1'(($urandom() >> 3) & 1);
            run_pulse(w, p);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired got cycles=%0d expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule